// File: doc/BRIEF.md
# Symbol Timing Interpolation Controller

This block is the timing-recovery core of a QPSK receiver whose matched filter delivers I and Q samples at two samples per symbol, one pair per clock. A piecewise-parabolic Farrow interpolator produces an output sample between two stored input samples at a fractional offset mu. A strobe-gated early-late detector measures timing error from three consecutive interpolator outputs. A proportional-plus-integral loop filter then drives a decrementing modulo-1 counter. When the counter underflows, it raises the symbol strobe and loads a new mu.

The interpolator and the error detector run on every sample. The counter, however, updates mu only on an underflow and holds it between strobes, so the interpolator always uses the offset of the current symbol. The strobe marks the interpolator output that a downstream decision stage should take, which is on average every second output. The carrier rotation, the decisions and everything ahead of the matched filter lie outside the block.

Fixed-point conventions: samples are signed DW-bit integers. The counter holds a CW-bit unsigned fraction of one, so one equals 2^CW. mu is an MUW-bit unsigned fraction, so one equals 2^MUW.

Top module: `sym_timing_ctrl`

## Requirements
- R1: While rst_ni is low, and until the first clock edge after its release, dout_i_o, dout_q_o, mu_o and strobe_o are all zero, and the counter holds CNT_INIT.
- R2: Let a, b, c, d be the four samples of one rail captured at the four clock edges just before the edge that loads an output, with a the newest. Let m be mu_o in the cycle before that edge. With V2 = a-b-c+d and V1 = 3b-a-c-d, the output is floor((c*2^(2*MUW+1) + m*(V1*2^MUW + m*V2)) / 2^(2*MUW+1)), clipped to the signed DW-bit range.
- R3: A constant input held on a rail for at least five cycles gives that same constant at the output, whatever the value of mu.
- R4: Each clock, the counter decreases by the step 2^(CW-1)+v, where v is the loop-filter output. A negative result is an underflow: 2^CW is added back. strobe_o is high exactly one cycle after the cycle in which an underflow loaded mu_o.
- R5: On an underflow, mu_o becomes floor(eta*2^MUW/step), where eta is the counter value before the decrement. Without an underflow, mu_o keeps its value.
- R6: With zero input and the default CNT_INIT of 3/4, strobe_o is high on every second cycle, starting at the third clock after reset release. From the second clock onwards, mu_o equals 2^(MUW-1).
- R7: The timing error is zero unless strobe_o was high in the previous cycle. When it was, the error is y1*(y0-y2) summed over I and Q, where y0 is the current output, y1 the previous output and y2 the one before that.
- R8: At each edge the integrator adds KI*e and saturates to +/-(2^(IW-1)-1). It does not wrap. v becomes (KP*e + new integrator) arithmetically shifted right by SHIFT, clipped to +/-(2^(CW-2)-1). The counter uses v one edge after it is computed.
- R9: The counter step always lies strictly between 2^(CW-2) and 3*2^(CW-2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, one I/Q pair per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i_i | input | DW | In-phase matched-filter sample, signed |
| din_q_i | input | DW | Quadrature matched-filter sample, signed |
| dout_i_o | output | DW | Interpolated in-phase sample, signed |
| dout_q_o | output | DW | Interpolated quadrature sample, signed |
| strobe_o | output | 1 | High when the current output is the on-time symbol sample |
| mu_o | output | MUW | Fractional interval held between strobes |

## Verification
The assertions take nothing for granted about the sample values: any signed DW-bit input must leave the integrator and the loop output within their limits, and must keep the counter step inside its band. The mu-hold property relies only on the two registers between a counter underflow and the strobe. The stimulus goes from a zero stretch, which pins the loop at exactly half a symbol per sample, to a long full-scale pseudo-random stretch. That stretch drives the detector hard enough to saturate both the integrator and the loop output, and it also forces interpolator clipping. Constant stretches then follow on a loop that has been left at an arbitrary mu.

// File: rtl/sym_timing_pkg.sv
package sym_timing_pkg;
  localparam int RAILS = 2;  // I and Q
  localparam int NTAPS = 4;  // interpolator input taps
  localparam int NYH   = 3;  // late, on-time, early outputs
endpackage

// File: rtl/farrow_pp.sv
module farrow_pp #(
  parameter int DW  = 12,
  parameter int MUW = 8
) (
  input  logic signed [DW-1:0] x0_i,
  input  logic signed [DW-1:0] x1_i,
  input  logic signed [DW-1:0] x2_i,
  input  logic signed [DW-1:0] x3_i,
  input  logic [MUW-1:0]       mu_i,
  output logic signed [DW-1:0] y_o
);
  localparam int AW = DW + 2*MUW + 8;
  localparam int SH = 2*MUW + 1;
  localparam logic signed [AW-1:0] YMAX = AW'((longint'(1) <<< (DW-1)) - 1);
  localparam logic signed [AW-1:0] YMIN = -YMAX - AW'(1);

  logic signed [AW-1:0] a0, a1, a2, a3, v1, v2, mus, acc, sh;

  always_comb begin
    a0  = AW'(x0_i);
    a1  = AW'(x1_i);
    a2  = AW'(x2_i);
    a3  = AW'(x3_i);
    mus = signed'(AW'({1'b0, mu_i}));
    // coefficients scaled by 2 (alpha = 1/2)
    v2  = a0 - a1 - a2 + a3;
    v1  = a1 + a1 + a1 - a0 - a2 - a3;
    acc = (a2 <<< SH) + mus * ((v1 <<< MUW) + mus * v2);
    sh  = acc >>> SH;
    if (sh > YMAX)      y_o = YMAX[DW-1:0];
    else if (sh < YMIN) y_o = YMIN[DW-1:0];
    else                y_o = sh[DW-1:0];
  end
endmodule

// File: rtl/el_ted.sv
module el_ted
  import sym_timing_pkg::*;
#(
  parameter int DW = 12,
  parameter int EW = 2*DW + 2
) (
  input  logic                 en_i,
  input  logic signed [DW-1:0] late_i  [RAILS],
  input  logic signed [DW-1:0] on_i    [RAILS],
  input  logic signed [DW-1:0] early_i [RAILS],
  output logic signed [EW-1:0] err_o
);
  logic signed [EW-1:0] term [RAILS];

  for (genvar r = 0; r < RAILS; r++) begin : g_term
    assign term[r] = EW'(on_i[r]) * (EW'(late_i[r]) - EW'(early_i[r]));
  end

  assign err_o = en_i ? (term[0] + term[1]) : '0;
endmodule

// File: rtl/pi_lf.sv
module pi_lf #(
  parameter int EW    = 26,
  parameter int CW    = 16,
  parameter int GW    = 16,
  parameter int IW    = 32,
  parameter int SHIFT = 20,
  parameter int KP    = 1100,
  parameter int KI    = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [EW-1:0] e_i,
  output logic signed [IW-1:0] integ_o,
  output logic signed [CW-1:0] v_o
);
  localparam int AW = EW + GW;
  localparam int SW = ((AW > IW) ? AW : IW) + 2;
  localparam logic signed [GW-1:0] KP_C = GW'(KP);
  localparam logic signed [GW-1:0] KI_C = GW'(KI);
  localparam logic signed [SW-1:0] IMAX = SW'((longint'(1) <<< (IW-1)) - 1);
  localparam logic signed [SW-1:0] VLIM = SW'((longint'(1) <<< (CW-2)) - 1);

  logic signed [SW-1:0] p_term, i_term, i_sum, i_new, tot, shv, v_new;

  always_comb begin
    p_term = SW'(AW'(KP_C) * AW'(e_i));
    i_term = SW'(AW'(KI_C) * AW'(e_i));
    i_sum  = SW'(integ_o) + i_term;
    if (i_sum > IMAX)       i_new = IMAX;
    else if (i_sum < -IMAX) i_new = -IMAX;
    else                    i_new = i_sum;
    tot = p_term + i_new;
    shv = tot >>> SHIFT;
    if (shv > VLIM)         v_new = VLIM;
    else if (shv < -VLIM)   v_new = -VLIM;
    else                    v_new = shv;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_o <= '0;
      v_o     <= '0;
    end else begin
      integ_o <= IW'(i_new);
      v_o     <= CW'(v_new);
    end
  end
endmodule

// File: rtl/mod1_ctrl.sv
module mod1_ctrl #(
  parameter int             CW       = 16,
  parameter int             MUW      = 8,
  parameter logic [CW-1:0]  CNT_INIT = CW'(3) << (CW-2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [CW-1:0] v_i,
  output logic signed [CW+1:0] step_o,
  output logic                 stb_o,
  output logic [MUW-1:0]       mu_o
);
  localparam logic signed [CW+1:0] HALF_S = (CW+2)'(longint'(1) <<< (CW-1));
  localparam logic signed [CW+1:0] ONE_S  = (CW+2)'(longint'(1) <<< CW);

  logic [CW-1:0]         cnt_q;
  logic signed [CW+1:0]  diff;
  logic                  und;
  logic [MUW-1:0]        mu_new;

  // restoring division, numerator below denominator on underflow
  function automatic logic [MUW-1:0] frac_div(input logic [CW-1:0] num,
                                              input logic [CW-1:0] den);
    logic [CW:0]    rem;
    logic [MUW-1:0] q;
    rem = {1'b0, num};
    q   = '0;
    for (int b = 0; b < MUW; b++) begin
      rem = rem << 1;
      q   = q << 1;
      if (rem >= {1'b0, den}) begin
        rem  = rem - {1'b0, den};
        q[0] = 1'b1;
      end
    end
    return q;
  endfunction

  always_comb begin
    step_o = HALF_S + (CW+2)'(v_i);
    diff   = signed'({2'b00, cnt_q}) - step_o;
    und    = diff[CW+1];
    mu_new = frac_div(cnt_q, step_o[CW-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_INIT;
      stb_o <= 1'b0;
      mu_o  <= '0;
    end else begin
      stb_o <= und;
      cnt_q <= und ? CW'(diff + ONE_S) : CW'(diff);
      if (und) mu_o <= mu_new;
    end
  end
endmodule

// File: rtl/sym_timing_ctrl.sv
module sym_timing_ctrl
  import sym_timing_pkg::*;
#(
  parameter int            DW       = 12,
  parameter int            MUW      = 8,
  parameter int            CW       = 16,
  parameter int            GW       = 16,
  parameter int            IW       = 32,
  parameter int            SHIFT    = 20,
  parameter int            KP       = 1100,
  parameter int            KI       = 3,
  parameter logic [CW-1:0] CNT_INIT = CW'(3) << (CW-2)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] din_i_i,
  input  logic signed [DW-1:0] din_q_i,
  output logic signed [DW-1:0] dout_i_o,
  output logic signed [DW-1:0] dout_q_o,
  output logic                 strobe_o,
  output logic [MUW-1:0]       mu_o
);
  localparam int EW = 2*DW + 2;

  logic signed [DW-1:0] din     [RAILS];
  logic signed [DW-1:0] yo      [RAILS];
  logic signed [DW-1:0] t_late  [RAILS];
  logic signed [DW-1:0] t_on    [RAILS];
  logic signed [DW-1:0] t_early [RAILS];
  logic                 stb_raw, stb_out_q, ted_en;
  logic signed [EW-1:0] ted_err;
  logic signed [IW-1:0] integ;
  logic signed [CW-1:0] lf_v;
  logic signed [CW+1:0] step;

  assign din[0] = din_i_i;
  assign din[1] = din_q_i;

  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    logic signed [DW-1:0] xd [NTAPS];
    logic signed [DW-1:0] yh [NYH];
    logic signed [DW-1:0] yint;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < NTAPS; k++) xd[k] <= '0;
        for (int k = 0; k < NYH; k++)   yh[k] <= '0;
      end else begin
        xd[0] <= din[r];
        for (int k = 1; k < NTAPS; k++) xd[k] <= xd[k-1];
        yh[0] <= yint;
        for (int k = 1; k < NYH; k++)   yh[k] <= yh[k-1];
      end
    end

    farrow_pp #(.DW(DW), .MUW(MUW)) u_interp (
      .x0_i (xd[0]),
      .x1_i (xd[1]),
      .x2_i (xd[2]),
      .x3_i (xd[3]),
      .mu_i (mu_o),
      .y_o  (yint)
    );

    assign yo[r]      = yh[0];
    assign t_late[r]  = yh[0];
    assign t_on[r]    = yh[1];
    assign t_early[r] = yh[2];
  end

  // strobe aligned first with the output, then with the on-time tap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_out_q <= 1'b0;
      ted_en    <= 1'b0;
    end else begin
      stb_out_q <= stb_raw;
      ted_en    <= stb_out_q;
    end
  end

  el_ted #(.DW(DW), .EW(EW)) u_ted (
    .en_i    (ted_en),
    .late_i  (t_late),
    .on_i    (t_on),
    .early_i (t_early),
    .err_o   (ted_err)
  );

  pi_lf #(
    .EW(EW), .CW(CW), .GW(GW), .IW(IW), .SHIFT(SHIFT), .KP(KP), .KI(KI)
  ) u_lf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .e_i     (ted_err),
    .integ_o (integ),
    .v_o     (lf_v)
  );

  mod1_ctrl #(.CW(CW), .MUW(MUW), .CNT_INIT(CNT_INIT)) u_ctr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .v_i    (lf_v),
    .step_o (step),
    .stb_o  (stb_raw),
    .mu_o   (mu_o)
  );

  assign dout_i_o = yo[0];
  assign dout_q_o = yo[1];
  assign strobe_o = stb_out_q;
endmodule

// File: rtl/sym_timing_chk.sv
module sym_timing_chk #(
  parameter int MUW = 8,
  parameter int CW  = 16,
  parameter int EW  = 26,
  parameter int IW  = 32
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [MUW-1:0]       mu_o,
  input logic                 strobe_o,
  input logic                 ted_en,
  input logic signed [EW-1:0] ted_err,
  input logic signed [IW-1:0] integ,
  input logic signed [CW-1:0] lf_v,
  input logic signed [CW+1:0] step
);
  localparam logic signed [IW-1:0]  IMAX = IW'((longint'(1) <<< (IW-1)) - 1);
  localparam logic signed [CW-1:0]  VLIM = CW'((longint'(1) <<< (CW-2)) - 1);
  localparam logic signed [CW+1:0]  QTR  = (CW+2)'(longint'(1) <<< (CW-2));
  localparam logic signed [CW+1:0]  QTR3 = (CW+2)'(longint'(3) <<< (CW-2));

  a_r5_mu_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mu_o) |=> strobe_o);

  a_r7_ted_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ted_en |-> (ted_err == '0));

  a_r8_integ_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (integ <= IMAX) && (integ >= -IMAX));

  a_r8_v_lim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lf_v <= VLIM) && (lf_v >= -VLIM));

  a_r9_step_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step > QTR) && (step < QTR3));
endmodule

bind sym_timing_ctrl sym_timing_chk #(
  .MUW(MUW), .CW(CW), .EW(EW), .IW(IW)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .mu_o     (mu_o),
  .strobe_o (strobe_o),
  .ted_en   (ted_en),
  .ted_err  (ted_err),
  .integ    (integ),
  .lf_v     (lf_v),
  .step     (step)
);

// File: tb/tb_sym_timing_ctrl.sv
`timescale 1ns/1ps
module tb_sym_timing_ctrl;
  localparam int DW    = 10;
  localparam int MUW   = 6;
  localparam int CW    = 12;
  localparam int GW    = 12;
  localparam int IW    = 20;
  localparam int SHIFT = 10;
  localparam int KP    = 2;
  localparam int KI    = 8;
  localparam longint CNT0 = longint'(3) << (CW-2);
  localparam longint HALF = longint'(1) << (CW-1);
  localparam longint ONE  = longint'(1) << CW;
  localparam longint IMAX = (longint'(1) << (IW-1)) - 1;
  localparam longint VLIM = (longint'(1) << (CW-2)) - 1;
  localparam longint YMAX = (longint'(1) << (DW-1)) - 1;
  localparam longint YMIN = -YMAX - 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic signed [DW-1:0] din_i = '0, din_q = '0;
  logic signed [DW-1:0] dout_i, dout_q;
  logic strobe;
  logic [MUW-1:0] mu;

  always #2.5 clk = ~clk;

  sym_timing_ctrl #(
    .DW(DW), .MUW(MUW), .CW(CW), .GW(GW), .IW(IW), .SHIFT(SHIFT), .KP(KP), .KI(KI)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .din_i_i(din_i), .din_q_i(din_q),
    .dout_i_o(dout_i), .dout_q_o(dout_q), .strobe_o(strobe), .mu_o(mu)
  );

  int n_tests = 0;
  int n_fail  = 0;
  int cyc_n   = 0;
  bit done    = 1'b0;

  // bench model state
  longint hi [4], hq [4];
  longint eyi, eyq, emu, mcnt, mmu, mv, minteg;
  bit     estb, mstb, s1;
  longint y1i, y1q, y2i, y2q;
  logic [31:0] lfsr = 32'h1234_5677;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc_n, act, exp);
    end
  endtask

  function automatic longint farrow(longint a, longint b, longint c, longint d, longint m);
    longint v1, v2, acc, y;
    v2  = a - b - c + d;
    v1  = 3*b - a - c - d;
    acc = c * (longint'(1) << (2*MUW+1)) + m * (v1 * (longint'(1) << MUW) + m * v2);
    y   = acc >>> (2*MUW+1);
    if (y > YMAX) y = YMAX;
    if (y < YMIN) y = YMIN;
    return y;
  endfunction

  // compare outputs against the predictions made one cycle earlier
  task automatic chk_cycle();
    check(longint'(dout_i) == eyi, "R2 dout_i", longint'(dout_i), eyi);
    check(longint'(dout_q) == eyq, "R2 dout_q", longint'(dout_q), eyq);
    check(strobe == estb, "R4 R7 strobe", longint'(strobe), longint'(estb));
    check(longint'(mu) == emu, "R5 R8 R9 mu", longint'(mu), emu);
  endtask

  // predict the next cycle, then drive the next input pair
  task automatic step_cycle(input logic signed [DW-1:0] ni, input logic signed [DW-1:0] nq);
    longint st, d, e, isum, tot, vv, oyi, oyq;
    bit und;
    oyi = longint'(dout_i);
    oyq = longint'(dout_q);
    eyi = farrow(hi[0], hi[1], hi[2], hi[3], longint'(mu));
    eyq = farrow(hq[0], hq[1], hq[2], hq[3], longint'(mu));
    // R4/R5 counter with the loop output of this cycle
    st = HALF + mv;
    d  = mcnt - st;
    und = (d < 0);
    if (und) begin
      mmu  = (mcnt << MUW) / st;
      mcnt = d + ONE;
    end else begin
      mcnt = d;
    end
    estb = mstb;
    mstb = und;
    emu  = mmu;
    // R7 detector, R8 filter
    e = s1 ? (y1i * (oyi - y2i) + y1q * (oyq - y2q)) : 0;
    isum = minteg + KI * e;
    if (isum > IMAX)  isum = IMAX;
    if (isum < -IMAX) isum = -IMAX;
    minteg = isum;
    tot = KP * e + minteg;
    vv  = tot >>> SHIFT;
    if (vv > VLIM)  vv = VLIM;
    if (vv < -VLIM) vv = -VLIM;
    mv  = vv;
    y2i = y1i; y2q = y1q;
    y1i = oyi; y1q = oyq;
    s1  = strobe;
    din_i = ni;
    din_q = nq;
    for (int k = 3; k > 0; k--) begin
      hi[k] = hi[k-1];
      hq[k] = hq[k-1];
    end
    hi[0] = longint'(ni);
    hq[0] = longint'(nq);
  endtask

  task automatic next_cycle(input logic signed [DW-1:0] ni, input logic signed [DW-1:0] nq);
    @(negedge clk);
    cyc_n++;
    chk_cycle();
    step_cycle(ni, nq);
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin hi[k] = 0; hq[k] = 0; end
    eyi = 0; eyq = 0; emu = 0; estb = 0;
    mcnt = CNT0; mmu = 0; mv = 0; minteg = 0; mstb = 0; s1 = 0;
    y1i = 0; y1q = 0; y2i = 0; y2q = 0;
    repeat (4) @(negedge clk);
    // R1: reset values while held
    check(dout_i == '0 && dout_q == '0, "R1 dout in reset", longint'(dout_i), 0);
    check(strobe == 1'b0, "R1 strobe in reset", longint'(strobe), 0);
    check(mu == '0, "R1 mu in reset", longint'(mu), 0);
    rst_ni = 1'b1;
    chk_cycle();
    step_cycle('0, '0);

    // R6: zero input, exact half-symbol step
    for (int t = 1; t <= 40; t++) begin
      next_cycle('0, '0);
      check(strobe == ((t >= 3) && (t % 2 == 1)), "R6 strobe pattern",
            longint'(strobe), longint'((t >= 3) && (t % 2 == 1)));
      if (t >= 2)
        check(longint'(mu) == (longint'(1) << (MUW-1)), "R6 mu half",
              longint'(mu), longint'(1) << (MUW-1));
    end

    // R2 R4 R5 R7 R8: full-scale pseudo-random I/Q, loop active
    for (int t = 0; t < 3000; t++) begin
      lfsr = lfsr ^ (lfsr << 13);
      lfsr = lfsr ^ (lfsr >> 17);
      lfsr = lfsr ^ (lfsr << 5);
      next_cycle(signed'(lfsr[DW-1:0]), signed'(lfsr[DW+11:12]));
    end

    // R3: constant stretches at whatever mu the loop left
    for (int c = 0; c < 8; c++) begin
      logic signed [DW-1:0] ci, cq;
      ci = DW'(c * 97 - 400);
      cq = DW'(300 - c * 83);
      for (int t = 0; t < 12; t++) begin
        next_cycle(ci, cq);
        if (t >= 5) begin
          check(dout_i == ci, "R3 constant I", longint'(dout_i), longint'(ci));
          check(dout_q == cq, "R3 constant Q", longint'(dout_q), longint'(cq));
        end
      end
    end

    repeat (4) next_cycle('0, '0);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog cycle %0d actual 0 expected 1", cyc_n);
      summary();
      $finish;
    end
  end
endmodule